// File: doc/BRIEF.md
# Serial PLL Synthesizer Loader

This block programs an external PLL synthesizer over a three-wire serial link. A one-cycle start request makes the block read six configuration bytes from a byte-wide store. The store's read port is combinational. The block then shifts these bytes out as two consecutive 24-bit frames, most significant bit first. The serial clock strobes each bit. After the last bit of each frame, a load-enable pulse tells the synthesizer to take the frame. A one-cycle done pulse closes the transfer.

The sequencer has six states:
- `S_IDLE` waits for start.
- `S_FETCH` reads one byte per cycle.
- `S_SCK_LOW` presents a data bit with the serial clock low.
- `S_SCK_HIGH` holds the bit while the serial clock is high.
- `S_LOAD_PULSE` drives load-enable.
- `S_FINISH` raises done.

The transitions are:
- start: `S_IDLE`→`S_FETCH`.
- fetch-complete: `S_FETCH`→`S_SCK_LOW`, after the sixth byte.
- half-elapsed: `S_SCK_LOW`→`S_SCK_HIGH`.
- next-bit: `S_SCK_HIGH`→`S_SCK_LOW`.
- frame-end: `S_SCK_HIGH`→`S_LOAD_PULSE`, after bit 24.
- next-frame: `S_LOAD_PULSE`→`S_SCK_LOW`.
- last-frame: `S_LOAD_PULSE`→`S_FINISH`.
- return: `S_FINISH`→`S_IDLE`.

Each serial clock phase lasts `HALF_PERIOD` system clocks. Load-enable lasts `LATCH_CYCLES` system clocks.

Top module: `syn_loader`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, the outputs are all low: ser_clk, ser_data, ser_le, done and rd_en.
- R2: An accepted start reads exactly six bytes on six consecutive cycles, one per cycle, with rd_en high. The addresses run 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, and the block captures rd_data in the same cycle as its address.
- R3: The block sends two frames of exactly 24 ser_clk rising edges each. Frame 1 is the bytes from 0x08, 0x09 and 0x0A, in that order. Frame 2 is the bytes from 0x0B, 0x0C and 0x0D.
- R4: Within a frame, bits go out most significant first: bit 7 of the lowest-addressed byte leads. Padding bits stored at the top of a frame therefore leave before the meaningful bits, unchanged.
- R5: ser_clk idles low. Every high phase and every low phase inside a frame lasts HALF_PERIOD clocks. ser_data changes only while ser_clk is low and stays stable throughout each high phase.
- R6: After the 24th rising edge of each frame, ser_le goes high for exactly LATCH_CYCLES clocks, right after the high phase ends, with ser_clk low. There is one pulse per frame.
- R7: done is high for one cycle, in the cycle right after the second load-enable pulse ends. With the defaults (HALF_PERIOD=2, LATCH_CYCLES=3), it is visible 204 cycles after the edge that accepts start.
- R8: A start asserted while a transfer is in progress is ignored: no new reads occur, and the frames, the timing and the single done pulse stay the same.
- R9: Reset asserted mid-transfer forces all outputs low at once and returns the sequencer to idle. The block stays idle until the next start, which then produces a complete, correct transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| rd_en | output | 1 | Byte read strobe to the configuration store |
| rd_addr | output | ADDR_W | Byte address presented to the store |
| rd_data | input | BYTE_W | Byte returned combinationally by the store |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_le | output | 1 | Load-enable strobe, one pulse per frame |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the frame boundary and at the byte order. A design that shifted one bit too few or too many would move every bit of frame 2 and change the rising-edge count. A design that swapped bytes or read from wrong addresses would produce frames that differ from the table, because the unused store locations hold a distinctive filler. Data that changes on the rising edge, or a latch strobe that overlaps a clock high phase, would show up as a stability or overlap violation. A design that honoured a second start mid-transfer would issue extra reads and shift the done cycle. A reset that failed to clear the sequencer would leave the outputs moving after reset is released.

// File: rtl/syn_pkg.sv
package syn_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SCK_LOW,
        S_SCK_HIGH,
        S_LOAD_PULSE,
        S_FINISH
    } syn_state_e;

endpackage

// File: rtl/syn_cycle_counter.sv
module syn_cycle_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/syn_frame_shifter.sv
module syn_frame_shifter #(
    parameter int WIDTH  = 48,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_byte,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              shift_bit,
    output logic              msb
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_byte) begin
            sr_q <= {sr_q[WIDTH-BYTE_W-1:0], byte_in};
        end else if (shift_bit) begin
            sr_q <= {sr_q[WIDTH-2:0], 1'b0};
        end
    end

    assign msb = sr_q[WIDTH-1];

endmodule

// File: rtl/syn_loader.sv
module syn_loader
    import syn_pkg::*;
#(
    parameter int unsigned BASE_ADDR    = 8,
    parameter int          ADDR_W       = 8,
    parameter int          BYTE_W       = 8,
    parameter int          FRAME_BITS   = 24,
    parameter int          FRAME_COUNT  = 2,
    parameter int          HALF_PERIOD  = 2,
    parameter int          LATCH_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_le,
    output logic              done
);

    localparam int BYTES_PER_FRAME = FRAME_BITS / BYTE_W;
    localparam int TOTAL_BYTES     = BYTES_PER_FRAME * FRAME_COUNT;
    localparam int TOTAL_BITS      = FRAME_BITS * FRAME_COUNT;
    localparam int LONGEST_PHASE   = (HALF_PERIOD > LATCH_CYCLES) ? HALF_PERIOD : LATCH_CYCLES;
    localparam int CNT_W           = $clog2(LONGEST_PHASE + 1);
    localparam int BIT_W           = $clog2(FRAME_BITS);
    localparam int FRM_W           = $clog2(FRAME_COUNT + 1);
    localparam int IDX_W           = $clog2(TOTAL_BYTES + 1);

    syn_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [FRM_W-1:0]  frm_q;
    logic [CNT_W-1:0]  phase_cnt;
    logic              phase_clr;
    logic              half_tick;
    logic              latch_tick;
    logic              last_byte;
    logic              last_bit;
    logic              last_frame;
    logic              shift_msb;

    assign half_tick  = (phase_cnt == CNT_W'(HALF_PERIOD - 1));
    assign latch_tick = (phase_cnt == CNT_W'(LATCH_CYCLES - 1));
    assign last_byte  = (idx_q == IDX_W'(TOTAL_BYTES - 1));
    assign last_bit   = (bit_q == BIT_W'(FRAME_BITS - 1));
    assign last_frame = (frm_q == FRM_W'(FRAME_COUNT - 1));
    assign phase_clr  = (state_q != state_d) || (state_q == S_IDLE);

    syn_cycle_counter #(.W(CNT_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .count (phase_cnt)
    );

    syn_frame_shifter #(.WIDTH(TOTAL_BITS), .BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_byte (state_q == S_FETCH),
        .byte_in   (rd_data),
        .shift_bit ((state_q == S_SCK_HIGH) && half_tick),
        .msb       (shift_msb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = S_FETCH;
            S_FETCH:      if (last_byte) state_d = S_SCK_LOW;
            S_SCK_LOW:    if (half_tick) state_d = S_SCK_HIGH;
            S_SCK_HIGH:   if (half_tick) state_d = last_bit ? S_LOAD_PULSE : S_SCK_LOW;
            S_LOAD_PULSE: if (latch_tick) state_d = last_frame ? S_FINISH : S_SCK_LOW;
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // Byte, bit and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            bit_q <= '0;
            frm_q <= '0;
        end else begin
            if (state_q == S_FETCH) begin
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                idx_q <= '0;
            end
            if (state_q == S_IDLE) begin
                bit_q <= '0;
            end else if ((state_q == S_SCK_HIGH) && half_tick) begin
                bit_q <= last_bit ? '0 : bit_q + BIT_W'(1);
            end
            if (state_q == S_IDLE) begin
                frm_q <= '0;
            end else if ((state_q == S_LOAD_PULSE) && latch_tick) begin
                frm_q <= frm_q + FRM_W'(1);
            end
        end
    end

    // Output decode
    always_comb begin
        rd_en    = (state_q == S_FETCH);
        rd_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(idx_q);
        ser_clk  = (state_q == S_SCK_HIGH);
        ser_le   = (state_q == S_LOAD_PULSE);
        done     = (state_q == S_FINISH);
        ser_data = ((state_q == S_SCK_LOW) || (state_q == S_SCK_HIGH)) ? shift_msb : 1'b0;
    end

    // R5: data held steady across a clock high phase
    assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R6: latch strobe begins right after a clock high phase
    assert_latch_after_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> $past(ser_clk));

    // R7: done immediately follows the end of a latch pulse
    assert_done_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ser_le));

    // R2: consecutive reads walk upward one address at a time
    assert_sequential_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R8: reads begin only from an idle sequencer that saw start
    assert_fetch_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> ($past(start) && $past(state_q == S_IDLE)));

endmodule

// File: tb/tb_syn_loader.sv
module tb_syn_loader;

    localparam int HALF     = 2;
    localparam int LAT      = 3;
    localparam int NBITS    = 24;
    localparam int EXP_DONE = 6 + 2 * NBITS * 2 * HALF + 2 * LAT;
    localparam int NVEC     = 5;
    // {six stored bytes, expected frame 1, expected frame 2}
    localparam logic [95:0] VEC [NVEC] = '{
        96'h123456789ABC_123456_789ABC,
        96'hFF0000000001_FF0000_000001,
        96'h800001AA55C3_800001_AA55C3,
        96'h000000FFFFFF_000000_FFFFFF,
        96'hA5A5A55A5A5A_A5A5A5_5A5A5A
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_en;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       ser_data, ser_clk, ser_le, done;
    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;

    // results captured by run_xfer
    logic [23:0] cap_f [2];
    int cap_bits [2];
    int le_w [2];
    int done_at, done_cnt, rd_cnt, viol_addr, viol_hi, viol_lo, viol_stable, viol_le_clk, viol_done_pos, le_cnt;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    syn_loader #(
        .BASE_ADDR(8), .ADDR_W(8), .BYTE_W(8), .FRAME_BITS(NBITS),
        .FRAME_COUNT(2), .HALF_PERIOD(HALF), .LATCH_CYCLES(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load_store(input logic [47:0] bytes);
        for (int a = 0; a < 256; a++) mem[a] = 8'hE7;
        for (int i = 0; i < 6; i++) mem[8 + i] = bytes[47 - 8*i -: 8];
    endtask

    // Starts a transfer and observes it at negative edges until done settles.
    task automatic run_xfer(input int extra_start_at);
        logic [23:0] rx = '0;
        int bits = 0, fi = 0, hi_len = 0, lo_len = 0, le_len = 0;
        logic prev_clk = 1'b0, prev_le = 1'b0, hold = 1'b0;
        bit in_frame = 1'b0;
        cap_f[0] = '0; cap_f[1] = '0; cap_bits[0] = 0; cap_bits[1] = 0;
        le_w[0] = 0; le_w[1] = 0;
        done_at = -1; done_cnt = 0; rd_cnt = 0; viol_addr = 0; viol_hi = 0; viol_lo = 0;
        viol_stable = 0; viol_le_clk = 0; viol_done_pos = 0; le_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (n == 0) start = 1'b0;
            if (n == extra_start_at) start = 1'b1;
            if (n == extra_start_at + 1) start = 1'b0;
            if (rd_en) begin
                if (rd_addr != 8'(8 + rd_cnt)) viol_addr++;
                rd_cnt++;
            end
            if (ser_clk && !prev_clk) begin
                rx = {rx[22:0], ser_data};
                bits++;
                hold = ser_data;
                hi_len = 1;
                if (in_frame && lo_len != HALF) viol_lo++;
            end else if (ser_clk) begin
                hi_len++;
                if (ser_data != hold) viol_stable++;
            end
            if (!ser_clk && prev_clk) begin
                if (hi_len != HALF) viol_hi++;
                lo_len = 0;
                in_frame = 1'b1;
            end
            if (!ser_clk && !ser_le) lo_len++;
            if (ser_le) begin
                if (ser_clk) viol_le_clk++;
                le_len++;
                if (!prev_le && fi < 2) begin
                    cap_f[fi] = rx;
                    cap_bits[fi] = bits;
                    rx = '0;
                    bits = 0;
                    in_frame = 1'b0;
                    lo_len = 0;
                    le_cnt++;
                end
            end
            if (!ser_le && prev_le) begin
                if (fi < 2) le_w[fi] = le_len;
                fi++;
                le_len = 0;
            end
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = n;
                if (!prev_le || fi != 2) viol_done_pos++;
            end
            prev_clk = ser_clk;
            prev_le = ser_le;
            if (done_at >= 0 && n >= done_at + 6) break;
        end
    endtask

    task automatic check_xfer(input logic [95:0] v, input string tag);
        check(cap_f[0] == v[47:24], "R3", {tag, " frame1 content"}, cap_f[0], v[47:24]);
        check(cap_f[1] == v[23:0], "R4", {tag, " frame2 msb-first"}, cap_f[1], v[23:0]);
        check(cap_bits[0] == NBITS && cap_bits[1] == NBITS, "R3", {tag, " bits per frame"},
              cap_bits[0] * 100 + cap_bits[1], NBITS * 100 + NBITS);
        check(rd_cnt == 6 && viol_addr == 0, "R2", {tag, " reads/addr errors"},
              rd_cnt * 100 + viol_addr, 600);
        check(viol_hi == 0 && viol_lo == 0 && viol_stable == 0, "R5", {tag, " phase/stability violations"},
              viol_hi + viol_lo + viol_stable, 0);
        check(le_cnt == 2 && le_w[0] == LAT && le_w[1] == LAT && viol_le_clk == 0, "R6",
              {tag, " latch pulses"}, le_cnt * 10000 + le_w[0] * 100 + le_w[1] + viol_le_clk * 1000000,
              2 * 10000 + LAT * 100 + LAT);
        check(done_at == EXP_DONE, "R7", {tag, " done cycle"}, done_at, EXP_DONE);
        check(done_cnt == 1 && viol_done_pos == 0, "R7", {tag, " done pulse count/position"},
              done_cnt * 10 + viol_done_pos, 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        load_store(48'h0);
        // R1: outputs low while held in reset
        repeat (4) @(negedge clk);
        check({ser_clk, ser_data, ser_le, done, rd_en} == 5'b0, "R1", "outputs during reset",
              {ser_clk, ser_data, ser_le, done, rd_en}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({ser_clk, ser_data, ser_le, done, rd_en} == 5'b0, "R1", "outputs idle after reset",
              {ser_clk, ser_data, ser_le, done, rd_en}, 0);

        // Table-driven transfers
        for (int v = 0; v < NVEC; v++) begin
            load_store(VEC[v][95:48]);
            run_xfer(-10);
            check_xfer(VEC[v], $sformatf("vec%0d", v));
        end

        // R8: a second start mid-transfer is ignored
        load_store(VEC[0][95:48]);
        run_xfer(50);
        check_xfer(VEC[0], "R8 restart-ignored");
        check(rd_cnt == 6, "R8", "reads with extra start", rd_cnt, 6);

        // R9: reset mid-transfer
        load_store(VEC[2][95:48]);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check({ser_clk, ser_data, ser_le, done, rd_en} == 5'b0, "R9", "outputs at mid-transfer reset",
              {ser_clk, ser_data, ser_le, done, rd_en}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        begin
            int act = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (ser_clk || ser_le || done || rd_en || ser_data) act++;
            end
            check(act == 0, "R9", "activity after reset release", act, 0);
        end
        run_xfer(-10);
        check_xfer(VEC[2], "R9 post-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule